// File: doc/BRIEF.md
# Double-data-rate octal memory bus master

This block turns single read or write requests from a local request port into transactions on an 8-bit double-data-rate memory bus. That bus has a chip select, a differential clock and one bidirectional strobe line. A request carries a word address, a register-or-memory space select, a burst type, a word count and, for writes, a stream of 16-bit words with byte enables. The master opens the transaction and sends a 48-bit command-address over three bus clocks. It waits out the initial latency and then moves 16-bit words, one byte per clock edge. It closes the transaction with the clock parked low.

The strobe line has three jobs. While the command-address goes out, the device holds it high to ask for doubled latency. During a read it marks the data bytes. During a write the master drives it as a per-byte mask. A bus-clock budget caps how long chip select stays low. When the budget runs out, a linear request is split into further transactions that resume at the next address. A wrapped request cannot be split that way, so it is stopped and flagged.

The block uses a single system clock. Each system cycle is one half-period of the bus clock, so the bus clock runs at half the system rate.

Top module: `ddr8_mem_master`

## Requirements
- R1: After reset, `cs_n_o` is 1, `ck_o` is 0, `ck_n_o` is 1, `dq_oe_o`, `rwds_oe_o` and `busy_o` are 0, and neither bus output is driven.
- R2: A transaction starts with one cycle in which `cs_n_o` is 0 and `ck_o` is 0. Six half-cycles follow, carrying the command-address most significant byte first. The byte for each odd position goes out while `ck_o` is 1, and `ck_o` toggles every cycle while `cs_n_o` stays low.
- R3: Command-address encoding: bit 47 is 1 for a read, bit 46 is 1 for register space, bit 45 is 1 for a linear burst (0 for wrapped), bits 34..16 carry address bits 21..3, bits 2..0 carry address bits 2..0, and every other bit is 0.
- R4: The first data half-cycle follows the command-address after 2*LAT half-cycles when `rwds_i` stays 0 through all six command half-cycles, and after 4*LAT half-cycles when it is 1 in any of them.
- R5: Write data: the upper byte of each word goes out while `ck_o` is 1 and the lower byte while it is 0. `rwds_o` is the inverse of the matching byte enable (1 means the byte is masked). `wdata_req_o` pulses in the lower-byte cycle of each word.
- R6: Read data: `dq_i` is taken as the upper byte when `rwds_i` rises and as the lower byte when it falls. The assembled word appears on `rdata_o` with a one-cycle `rdata_valid_o` pulse, and words arrive in address order.
- R7: After the last word, `cs_n_o` rises in a cycle where `ck_o` is 0, and `done_o` then pulses for one cycle.
- R8: Chip select never stays low for more than MAX_CK bus clocks. A linear request that needs more is continued in new transactions whose command-address starts at the first word not yet moved.
- R9: A wrapped request that exceeds the budget ends after the words that fit. `done_o` and `err_o` then pulse together, and no further transaction follows.
- R10: A request of length 0 pulses `done_o` and `err_o` together and leaves the bus idle.
- R11: During the read data phase, both `dq_oe_o` and `rwds_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, two cycles per bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| reg_space_i | input | 1 | 1 = register space, 0 = memory space |
| linear_i | input | 1 | 1 = linear burst, 0 = wrapped |
| addr_i | input | ADDR_W | Start word address |
| len_i | input | LEN_W | Number of words |
| wdata_i | input | 16 | Current write word |
| wbe_i | input | 2 | Byte enables for the current write word ([1] = upper) |
| wdata_req_o | output | 1 | Current write word consumed |
| rdata_o | output | 16 | Read word |
| rdata_valid_o | output | 1 | Read word valid pulse |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Request finished pulse |
| err_o | output | 1 | Request rejected or cut short, with done |
| cs_n_o | output | 1 | Chip select, active low |
| ck_o | output | 1 | Bus clock, true |
| ck_n_o | output | 1 | Bus clock, complement |
| dq_o | output | 8 | Data/command byte out |
| dq_oe_o | output | 1 | Drive enable for dq |
| dq_i | input | 8 | Data byte in |
| rwds_o | output | 1 | Strobe out (write mask) |
| rwds_oe_o | output | 1 | Drive enable for the strobe |
| rwds_i | input | 1 | Strobe in (latency request, read timing) |

## Verification
The request table mixes reads and writes, both address spaces, both burst types, addresses with high and low bits set, and the device asking for extra latency or not. A bus-side device model decodes every command-address and logs every byte and mask, so swapped or misplaced fields, wrong latency and a wrong byte order each show up as distinct mismatches. Two linear requests longer than one transaction's budget, one read and one write, show whether the split resumes at the right address. A wrapped write of the same length must stop with an error, and a zero-length request must leave the bus untouched.

// File: rtl/ddr8_pkg.sv
package ddr8_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_CA, ST_LAT, ST_DATA, ST_END
  } ddr8_st_e;
endpackage

// File: rtl/ddr8_ca_enc.sv
module ddr8_ca_enc #(
  parameter int unsigned ADDR_W = 22
) (
  input  logic              rd_i,
  input  logic              reg_space_i,
  input  logic              linear_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        idx_i,
  output logic [7:0]        byte_o
);
  localparam int unsigned RSV_W = 32 - ADDR_W;

  logic [47:0] ca;
  logic [47:0] shifted;

  assign ca = {rd_i, reg_space_i, linear_i, {RSV_W{1'b0}},
               addr_i[ADDR_W-1:3], 13'd0, addr_i[2:0]};
  assign shifted = ca << {idx_i, 3'b000};
  assign byte_o  = shifted[47:40];
endmodule

// File: rtl/ddr8_budget.sv
module ddr8_budget #(
  parameter int unsigned MAX_CK = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  output logic empty_o
);
  localparam int unsigned BW = $clog2(MAX_CK + 1);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= BW'(MAX_CK);
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/ddr8_rd_capture.sv
module ddr8_rd_capture (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic        rwds_i,
  input  logic [7:0]  dq_i,
  output logic        lo_o,
  output logic [15:0] word_o,
  output logic        valid_o
);
  logic       prev_q;
  logic [7:0] hi_q;
  logic       hi_now;

  assign hi_now = en_i && !prev_q && rwds_i;
  assign lo_o   = en_i && prev_q && !rwds_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      hi_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      prev_q  <= clr_i ? 1'b0 : rwds_i;
      valid_o <= lo_o;
      if (hi_now) hi_q   <= dq_i;
      if (lo_o)   word_o <= {hi_q, dq_i};
    end
  end
endmodule

// File: rtl/ddr8_mem_master.sv
module ddr8_mem_master
  import ddr8_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned LAT    = 6,
  parameter int unsigned MAX_CK = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic              reg_space_i,
  input  logic              linear_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        wbe_i,
  output logic              wdata_req_o,
  output logic [15:0]       rdata_o,
  output logic              rdata_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cs_n_o,
  output logic              ck_o,
  output logic              ck_n_o,
  output logic [7:0]        dq_o,
  output logic              dq_oe_o,
  input  logic [7:0]        dq_i,
  output logic              rwds_o,
  output logic              rwds_oe_o,
  input  logic              rwds_i
);
  localparam int unsigned CNT_W = $clog2(4 * LAT + 8);
  localparam logic [CNT_W-1:0] LAT_N = CNT_W'(2 * LAT - 1);
  localparam logic [CNT_W-1:0] LAT_X = CNT_W'(4 * LAT - 1);
  localparam logic [CNT_W-1:0] CA_LAST = CNT_W'(5);

  ddr8_st_e          st_q;
  logic [CNT_W-1:0]  hc_q;
  logic              ck_q, extra_q, stop_q;
  logic              rd_q, as_q, lin_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic              done_q, err_q;

  logic       bud_empty, cap_lo, in_data, wr_data, word_evt, stop_now, leave;
  logic [7:0] ca_byte;

  ddr8_ca_enc #(.ADDR_W(ADDR_W)) u_ca (
    .rd_i(rd_q), .reg_space_i(as_q), .linear_i(lin_q), .addr_i(addr_q),
    .idx_i(hc_q[2:0]), .byte_o(ca_byte)
  );

  ddr8_budget #(.MAX_CK(MAX_CK)) u_budget (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(st_q == ST_START),
    .tick_i(ck_q && (st_q inside {ST_CA, ST_LAT, ST_DATA})),
    .empty_o(bud_empty)
  );

  ddr8_rd_capture u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(st_q == ST_START),
    .en_i(in_data && rd_q), .rwds_i(rwds_i), .dq_i(dq_i),
    .lo_o(cap_lo), .word_o(rdata_o), .valid_o(rdata_valid_o)
  );

  assign in_data  = (st_q == ST_DATA);
  assign wr_data  = in_data && !rd_q;
  assign word_evt = in_data && (rd_q ? cap_lo : !ck_q);
  assign stop_now = word_evt && (left_q == LEN_W'(1) || bud_empty);
  // close only with the clock parked low
  assign leave    = in_data && !ck_q && (stop_now || stop_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      hc_q    <= '0;
      ck_q    <= 1'b0;
      extra_q <= 1'b0;
      stop_q  <= 1'b0;
      rd_q    <= 1'b0;
      as_q    <= 1'b0;
      lin_q   <= 1'b0;
      addr_q  <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          ck_q <= 1'b0;
          if (req_i) begin
            if (len_i == '0) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else begin
              rd_q   <= rd_i;
              as_q   <= reg_space_i;
              lin_q  <= linear_i;
              addr_q <= addr_i;
              left_q <= len_i;
              st_q   <= ST_START;
            end
          end
        end
        ST_START: begin
          ck_q    <= 1'b1;
          hc_q    <= '0;
          extra_q <= 1'b0;
          stop_q  <= 1'b0;
          st_q    <= ST_CA;
        end
        ST_CA: begin
          ck_q    <= ~ck_q;
          extra_q <= extra_q | rwds_i;
          if (hc_q == CA_LAST) begin
            hc_q <= '0;
            st_q <= ST_LAT;
          end else begin
            hc_q <= hc_q + 1'b1;
          end
        end
        ST_LAT: begin
          ck_q <= ~ck_q;
          if (hc_q == (extra_q ? LAT_X : LAT_N)) begin
            hc_q <= '0;
            st_q <= ST_DATA;
          end else begin
            hc_q <= hc_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (word_evt) begin
            left_q <= left_q - 1'b1;
            addr_q <= addr_q + 1'b1;
          end
          if (stop_now) stop_q <= 1'b1;
          if (leave) begin
            ck_q <= 1'b0;
            st_q <= ST_END;
          end else begin
            ck_q <= ~ck_q;
          end
        end
        ST_END: begin
          ck_q <= 1'b0;
          if (left_q == '0) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (lin_q) begin
            st_q <= ST_START;
          end else begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign cs_n_o      = (st_q == ST_IDLE) || (st_q == ST_END);
  assign ck_o        = ck_q;
  assign ck_n_o      = ~ck_q;
  assign dq_oe_o     = (st_q == ST_CA) || wr_data;
  assign rwds_oe_o   = wr_data;
  assign wdata_req_o = wr_data && !ck_q;

  always_comb begin
    dq_o   = '0;
    rwds_o = 1'b0;
    if (st_q == ST_CA) begin
      dq_o = ca_byte;
    end else if (wr_data) begin
      dq_o   = ck_q ? wdata_i[15:8] : wdata_i[7:0];
      rwds_o = ck_q ? ~wbe_i[1] : ~wbe_i[0];
    end
  end
endmodule

// File: rtl/ddr8_mem_master_chk.sv
module ddr8_mem_master_chk #(
  parameter int unsigned MAX_CK = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_n_o,
  input logic ck_o,
  input logic dq_oe_o,
  input logic rwds_oe_o,
  input logic rdata_valid_o,
  input logic done_o,
  input logic err_o
);
  logic [15:0] cs_clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cs_clk_q <= '0;
    else if (cs_n_o) cs_clk_q <= '0;
    else if (ck_o)   cs_clk_q <= cs_clk_q + 1'b1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (!ck_o && !dq_oe_o && !rwds_oe_o));

  a_r2_cs_fall_ck_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> !ck_o);

  a_r2_ck_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !$past(cs_n_o)) |-> (ck_o != $past(ck_o)));

  a_r5_mask_with_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwds_oe_o |-> dq_oe_o);

  a_r7_cs_rise_ck_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> !ck_o);

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_cs_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_clk_q <= 16'(MAX_CK));

  a_r9_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r11_read_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> (!dq_oe_o && !rwds_oe_o));
endmodule

bind ddr8_mem_master ddr8_mem_master_chk #(.MAX_CK(MAX_CK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_o(cs_n_o), .ck_o(ck_o),
  .dq_oe_o(dq_oe_o), .rwds_oe_o(rwds_oe_o), .rdata_valid_o(rdata_valid_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/ddr8_mem_master_tb.sv
`timescale 1ns/1ps
module ddr8_mem_master_tb;
  localparam int LAT = 6;
  localparam int MAX_CK = 32;

  typedef struct packed {
    logic        rd;
    logic        sp;
    logic        lin;
    logic [21:0] addr;
    logic [7:0]  len;
    logic        x;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 22'h012345, 8'd4,  1'b0},
    '{1'b0, 1'b1, 1'b0, 22'h3FFFF8, 8'd2,  1'b1},
    '{1'b1, 1'b0, 1'b1, 22'h000100, 8'd3,  1'b0},
    '{1'b1, 1'b0, 1'b0, 22'h2A5A07, 8'd5,  1'b1},
    '{1'b0, 1'b0, 1'b1, 22'h000010, 8'd20, 1'b1},
    '{1'b1, 1'b0, 1'b1, 22'h1FFFF0, 8'd25, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, rd = 1'b0, sp = 1'b0, lin = 1'b0;
  logic [21:0] addr = '0;
  logic [7:0]  len = '0;
  logic [15:0] wdata, rdata;
  logic [1:0]  wbe;
  logic wdata_req, rvalid, busy, done, err;
  logic cs_n, ck, ck_n, dq_oe, rwds, rwds_oe;
  logic [7:0] dq_out;
  logic [7:0] dev_dq = '0;
  logic dev_rwds = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ddr8_mem_master #(.ADDR_W(22), .LEN_W(8), .LAT(LAT), .MAX_CK(MAX_CK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rd_i(rd), .reg_space_i(sp),
    .linear_i(lin), .addr_i(addr), .len_i(len), .wdata_i(wdata), .wbe_i(wbe),
    .wdata_req_o(wdata_req), .rdata_o(rdata), .rdata_valid_o(rvalid),
    .busy_o(busy), .done_o(done), .err_o(err), .cs_n_o(cs_n), .ck_o(ck),
    .ck_n_o(ck_n), .dq_o(dq_out), .dq_oe_o(dq_oe), .dq_i(dev_dq),
    .rwds_o(rwds), .rwds_oe_o(rwds_oe), .rwds_i(dev_rwds)
  );

  function automatic logic [15:0] wdat(int k);
    logic [7:0] b = k[7:0];
    return {b ^ 8'hC3, b + 8'h21};
  endfunction
  function automatic logic [1:0] wbef(int k);
    return k[1:0] ^ 2'b01;
  endfunction
  function automatic logic [15:0] rdw(logic [21:0] a);
    return a[15:0] ^ 16'hA55A;
  endfunction
  function automatic logic [47:0] exp_ca(logic r, logic s, logic l, logic [21:0] a);
    logic [47:0] c = '0;
    c[47] = r; c[46] = s; c[45] = l;
    c[34:16] = a[21:3];
    c[2:0] = a[2:0];
    return c;
  endfunction

  // host side and device model
  int widx = 0;
  assign wdata = wdat(widx);
  assign wbe   = wbef(widx);

  int j = 0, tx_cnt = 0, tx0 = 0, wr_n = 0, rd_n = 0, first_wj = -1;
  int ckh = 0, max_ck = 0, oe_bad = 0, dstart = 0;
  bit dev_extra = 0, drd = 0, done_seen = 0, err_seen = 0;
  logic [47:0] sh, first_ca, last_ca;
  logic [21:0] dbase;
  logic [7:0] hb;
  logic hm;
  logic [17:0] wr_log [64];
  logic [15:0] rd_log [64];

  always @(negedge clk) begin
    if (cs_n) begin
      j = 0;
      dev_rwds <= 1'b0;
    end else begin
      if (j == 0) begin
        tx_cnt++;
        ckh = 0;
        dev_rwds <= dev_extra;
      end
      if (ck) begin
        ckh++;
        if (ckh > max_ck) max_ck = ckh;
      end
      if (j >= 1 && j <= 6) sh = {sh[39:0], dq_out};
      if (j == 6) begin
        last_ca = sh;
        if (tx_cnt == tx0 + 1) first_ca = sh;
        dbase  = {sh[34:16], sh[2:0]};
        drd    = sh[47];
        dstart = 7 + (dev_extra ? 4 : 2) * LAT;
      end
      if (j == 7) dev_rwds <= 1'b0;
      if (j >= 7 && rwds_oe) begin
        if (first_wj < 0) first_wj = j;
        if (ck) begin
          hb = dq_out; hm = rwds;
        end else if (wr_n < 64) begin
          wr_log[wr_n] = {hm, hb, rwds, dq_out};
          wr_n++;
        end
      end
      if (j >= 7 && drd && j >= dstart) begin
        logic [15:0] w;
        w = rdw(dbase + 22'((j - dstart) / 2));
        dev_rwds <= ck;
        dev_dq   <= ck ? w[15:8] : w[7:0];
        if (dq_oe || rwds_oe) oe_bad++;
      end
      j++;
    end
    if (wdata_req) widx++;
    if (rvalid && rd_n < 64) begin
      rd_log[rd_n] = rdata;
      rd_n++;
    end
    if (done) begin
      done_seen = 1;
      err_seen  = err;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic run(input vec_t v);
    int wpt, ntx, words, bad;
    bit eerr;
    wpt = MAX_CK - 3 - LAT * (v.x ? 2 : 1);
    if (v.len == 0) begin
      ntx = 0; words = 0; eerr = 1;
    end else if (!v.lin && int'(v.len) > wpt) begin
      ntx = 1; words = wpt; eerr = 1;
    end else begin
      ntx = (int'(v.len) + wpt - 1) / wpt; words = int'(v.len); eerr = 0;
    end
    @(negedge clk);
    wr_n = 0; rd_n = 0; first_wj = -1; max_ck = 0; oe_bad = 0; widx = 0;
    tx0 = tx_cnt; done_seen = 0; err_seen = 0; dev_extra = v.x;
    rd = v.rd; sp = v.sp; lin = v.lin; addr = v.addr; len = v.len; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (!done_seen) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(err_seen == eerr, "R7/R9/R10 done and err", 64'(err_seen), 64'(eerr));
    chk(tx_cnt - tx0 == ntx, "R8/R9/R10 transaction count", 64'(tx_cnt - tx0), 64'(ntx));
    chk(max_ck <= MAX_CK, "R8 chip select budget", 64'(max_ck), 64'(MAX_CK));
    if (ntx > 0) begin
      logic [47:0] e1, e2;
      e1 = exp_ca(v.rd, v.sp, v.lin, v.addr);
      chk(first_ca == e1, "R3 command-address", 64'(first_ca), 64'(e1));
      if (ntx > 1) begin
        e2 = exp_ca(v.rd, v.sp, v.lin, v.addr + 22'(wpt * (ntx - 1)));
        chk(last_ca == e2, "R8 split resume address", 64'(last_ca), 64'(e2));
      end
    end
    if (v.rd) begin
      bad = 0;
      for (int k = 0; k < words; k++)
        if (rd_log[k] != rdw(v.addr + 22'(k))) bad++;
      chk(rd_n == words, "R6 read word count", 64'(rd_n), 64'(words));
      chk(bad == 0, "R6 read word values", 64'(bad), 64'd0);
      if (ntx > 0) chk(oe_bad == 0, "R11 bus released in read", 64'(oe_bad), 64'd0);
    end else begin
      bad = 0;
      for (int k = 0; k < words; k++) begin
        logic [15:0] d;
        logic [1:0] m;
        d = wdat(k); m = wbef(k);
        if (wr_log[k] != {~m[1], d[15:8], ~m[0], d[7:0]}) bad++;
      end
      chk(wr_n == words, "R5 write word count", 64'(wr_n), 64'(words));
      chk(bad == 0, "R5 write bytes and masks", 64'(bad), 64'd0);
      if (ntx > 0)
        chk(first_wj == 7 + (v.x ? 4 : 2) * LAT, "R2/R4 latency to first data",
            64'(first_wj), 64'(7 + (v.x ? 4 : 2) * LAT));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n && !ck && ck_n && !dq_oe && !rwds_oe && !busy, "R1 reset state",
        64'({cs_n, ck, ck_n, dq_oe, rwds_oe, busy}), 64'b101000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && !ck && !busy, "R1 idle after reset", 64'({cs_n, ck, busy}), 64'b100);
    for (int i = 0; i < NV; i++) run(VEC[i]);
    // R9: wrapped request past the budget
    run('{1'b0, 1'b0, 1'b0, 22'h000040, 8'd20, 1'b1});
    // R10: zero length leaves bus idle
    run('{1'b1, 1'b0, 1'b1, 22'h000001, 8'd0, 1'b0});
    chk(cs_n && !busy, "R10 bus idle", 64'({cs_n, busy}), 64'b10);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule